// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves one PLL to a new operating point on request. The requester supplies the four PLL codes: input divider, feedback divider, output divider and band. It also supplies one flag that says whether the new core rate lies above the core-interface threshold. The block latches the request. It then performs a fixed series of accesses over a simple single-outstanding register bus. It writes the PLL control word and waits out the lock window. It then reads the PLL status register and reports the outcome.

A separate divider register sets the core-interface clock. The block updates it in an order that depends on the threshold flag. For a fast target, the divider is raised to divide-by-2 before the PLL is touched. For a slow target, it is lowered to divide-by-1 only after the PLL has locked cleanly. The interface clock therefore never runs beyond its limit, not even while the PLL is moving.

Top module: `pll_reprog_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `bus_req_o` are low.
- R2: The control word written to `CTRL_ADDR` holds the output-divider code in bits 3:2, the input-divider code in bits 8:4, the feedback-divider code in bits 15:9 and the band code in bits 23:20. Bits 1 (bypass) and 0 (power-down) are zero, and all other bits are zero.
- R3: When `above_thr_i` is set, the value 1 (divide-by-2) is written to `CIF_ADDR` before the control word is written. The divider is never written back to 0 within that request.
- R4: When `above_thr_i` is clear, the value 0 (divide-by-1) is written to `CIF_ADDR` after the status read, and only if the result is ok. When the result is timeout or error, no divider write occurs.
- R5: The status read completes no fewer than `LOCK_CYCLES` clock cycles after the control write completes.
- R6: Status bit 0 is lock and bit 1 is error. If lock is 0, the result is timeout (2'b01) whatever the error bit holds. If lock is 1 and error is 1, the result is error (2'b10). If lock is 1 and error is 0, the result is ok (2'b00).
- R7: `busy_o` rises in the cycle after a request is accepted and stays high through a single-cycle `done_o` pulse. `done_o` carries `result_o`, and `busy_o` falls in the next cycle.
- R8: `req_i` pulses while `busy_o` is high are ignored. They change neither the written words nor the outcome.
- R9: Each bus access holds `bus_req_o`, address and write data stable until `bus_ack_i`. Exactly one status read is made per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a reprogramming request (sampled when idle) |
| idiv_i | input | 5 | Input-divider code |
| fbdiv_i | input | 7 | Feedback-divider code |
| odiv_i | input | 2 | Output-divider code |
| band_i | input | 4 | Band code |
| above_thr_i | input | 1 | Target core rate is above the interface threshold |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 ok, 01 timeout, 10 error; valid with done_o |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Access complete |

## Verification
A sequencer stuck in a wrong state shows up at once on the bus. The order of the divider and control writes changes, a write goes missing or is added, or the status read comes early. All of this is visible inside the same request. A miscounted lock window shifts the status read relative to the control write, and that gap is measured on every request. A wrong decision on the latched status shows as a wrong `result_o` on the `done_o` pulse, or as a divider write that should not exist. A `busy_o`/`done_o` sequence that is off by one cycle appears within one cycle of completion.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;
  localparam int ODIV_LSB  = 2;
  localparam int IDIV_LSB  = 4;
  localparam int FBDIV_LSB = 9;
  localparam int BAND_LSB  = 20;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_TIMEOUT = 2'b01,
    RES_ERROR   = 2'b10
  } result_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CIF_UP,
    S_CTRL_WR,
    S_WAIT,
    S_STAT_RD,
    S_CIF_DN,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_reprog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDIV_W  = 5,
  parameter int FBDIV_W = 7,
  parameter int ODIV_W  = 2,
  parameter int BAND_W  = 4
) (
  input  logic [IDIV_W-1:0]  idiv_i,
  input  logic [FBDIV_W-1:0] fbdiv_i,
  input  logic [ODIV_W-1:0]  odiv_i,
  input  logic [BAND_W-1:0]  band_i,
  output logic [DATA_W-1:0]  word_o
);
  // power-down (bit 0) and bypass (bit 1) stay cleared
  always_comb begin
    word_o = '0;
    word_o[ODIV_LSB  +: ODIV_W]  = odiv_i;
    word_o[IDIV_LSB  +: IDIV_W]  = idiv_i;
    word_o[FBDIV_LSB +: FBDIV_W] = fbdiv_i;
    word_o[BAND_LSB  +: BAND_W]  = band_i;
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_reprog_ctrl.sv
module pll_reprog_ctrl
  import pll_reprog_pkg::*;
#(
  parameter int         LOCK_CYCLES = 10000,
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 32,
  parameter int         IDIV_W      = 5,
  parameter int         FBDIV_W     = 7,
  parameter int         ODIV_W      = 2,
  parameter int         BAND_W      = 4,
  parameter logic [7:0] CTRL_ADDR   = 8'h00,
  parameter logic [7:0] STAT_ADDR   = 8'h04,
  parameter logic [7:0] CIF_ADDR    = 8'h80
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [IDIV_W-1:0]  idiv_i,
  input  logic [FBDIV_W-1:0] fbdiv_i,
  input  logic [ODIV_W-1:0]  odiv_i,
  input  logic [BAND_W-1:0]  band_i,
  input  logic               above_thr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         result_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  input  logic               bus_ack_i
);
  localparam int WCNT_W = $clog2(LOCK_CYCLES + 2);
  localparam logic [DATA_W-1:0] CIF_DIV1 = '0;
  localparam logic [DATA_W-1:0] CIF_DIV2 = DATA_W'(1);

  seq_state_e         state_q, state_d;
  logic [IDIV_W-1:0]  idiv_q;
  logic [FBDIV_W-1:0] fbdiv_q;
  logic [ODIV_W-1:0]  odiv_q;
  logic [BAND_W-1:0]  band_q;
  logic               above_q;
  result_e            result_q, result_d;
  logic [DATA_W-1:0]  ctrl_word;
  logic               timer_load, timer_zero;
  logic               accept, xfer;
  logic               stat_lock, stat_err;
  logic               unused_rdata;

  assign accept       = (state_q == S_IDLE) && req_i;
  assign xfer         = bus_req_o && bus_ack_i;
  assign stat_lock    = bus_rdata_i[0];
  assign stat_err     = bus_rdata_i[1];
  assign unused_rdata = ^bus_rdata_i[DATA_W-1:2];
  assign timer_load   = (state_q == S_CTRL_WR) && bus_ack_i;

  pll_word_pack #(
    .DATA_W(DATA_W), .IDIV_W(IDIV_W), .FBDIV_W(FBDIV_W),
    .ODIV_W(ODIV_W), .BAND_W(BAND_W)
  ) u_pack (
    .idiv_i (idiv_q),
    .fbdiv_i(fbdiv_q),
    .odiv_i (odiv_q),
    .band_i (band_q),
    .word_o (ctrl_word)
  );

  pll_lock_timer #(.CYCLES(LOCK_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(timer_load),
    .zero_o(timer_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idiv_q  <= '0;
      fbdiv_q <= '0;
      odiv_q  <= '0;
      band_q  <= '0;
      above_q <= 1'b0;
    end else if (accept) begin
      idiv_q  <= idiv_i;
      fbdiv_q <= fbdiv_i;
      odiv_q  <= odiv_i;
      band_q  <= band_i;
      above_q <= above_thr_i;
    end
  end

  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    unique case (state_q)
      S_IDLE:    if (req_i) state_d = above_thr_i ? S_CIF_UP : S_CTRL_WR;
      S_CIF_UP:  if (bus_ack_i) state_d = S_CTRL_WR;
      S_CTRL_WR: if (bus_ack_i) state_d = S_WAIT;
      S_WAIT:    if (timer_zero) state_d = S_STAT_RD;
      S_STAT_RD: if (bus_ack_i) begin
        if (!stat_lock) begin
          result_d = RES_TIMEOUT;
          state_d  = S_DONE;
        end else if (stat_err) begin
          result_d = RES_ERROR;
          state_d  = S_DONE;
        end else begin
          result_d = RES_OK;
          state_d  = above_q ? S_DONE : S_CIF_DN;
        end
      end
      S_CIF_DN:  if (bus_ack_i) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      result_q <= RES_OK;
    end else begin
      state_q  <= state_d;
      result_q <= result_d;
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b1;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_CIF_UP: begin
        bus_req_o   = 1'b1;
        bus_addr_o  = ADDR_W'(CIF_ADDR);
        bus_wdata_o = CIF_DIV2;
      end
      S_CTRL_WR: begin
        bus_req_o   = 1'b1;
        bus_addr_o  = ADDR_W'(CTRL_ADDR);
        bus_wdata_o = ctrl_word;
      end
      S_STAT_RD: begin
        bus_req_o  = 1'b1;
        bus_we_o   = 1'b0;
        bus_addr_o = ADDR_W'(STAT_ADDR);
      end
      S_CIF_DN: begin
        bus_req_o   = 1'b1;
        bus_addr_o  = ADDR_W'(CIF_ADDR);
        bus_wdata_o = CIF_DIV1;
      end
      default: ;
    endcase
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign result_o = result_q;

  // ---------------- assertions ----------------
  logic [WCNT_W-1:0] wait_cnt_q;
  logic              cif_up_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_cnt_q    <= '0;
      cif_up_seen_q <= 1'b0;
    end else begin
      if (timer_load)                                wait_cnt_q <= '0;
      else if (wait_cnt_q != {WCNT_W{1'b1}})         wait_cnt_q <= wait_cnt_q + 1'b1;
      if (state_q == S_IDLE)                         cif_up_seen_q <= 1'b0;
      else if (xfer && bus_we_o && bus_addr_o == ADDR_W'(CIF_ADDR) && bus_wdata_o == CIF_DIV2)
                                                     cif_up_seen_q <= 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> !busy_o && !bus_req_o);

  // R2
  ctrl_word_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(CTRL_ADDR) |-> bus_wdata_o[1:0] == 2'b00);

  // R3
  cif_raise_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(CTRL_ADDR) && above_q |-> cif_up_seen_q);

  // R4
  cif_lower_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(CIF_ADDR) && bus_wdata_o == CIF_DIV1
    |-> !above_q && result_q == RES_OK);

  // R5
  lock_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> 32'(wait_cnt_q) >= LOCK_CYCLES);

  // R6
  result_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o != 2'b11);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  // R9
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_wdata_o)
    && $stable(bus_we_o));
endmodule

// File: tb/pll_reprog_ctrl_tb.sv
module pll_reprog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 20;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_CIF  = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [4:0]  idiv = '0;
  logic [6:0]  fbdiv = '0;
  logic [1:0]  odiv = '0;
  logic [3:0]  band = '0;
  logic        above = 1'b0;
  logic        busy, done;
  logic [1:0]  result;
  logic        bus_req, bus_we, bus_ack;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  status = 2'b00;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int wr_n = 0;
  int rd_n = 0;
  int ctrl_cyc = 0;
  int stat_cyc = 0;
  logic [7:0]  wr_addr [64];
  logic [31:0] wr_data [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_reprog_ctrl #(.LOCK_CYCLES(LOCK), .CTRL_ADDR(A_CTRL), .STAT_ADDR(A_STAT),
                    .CIF_ADDR(A_CIF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .idiv_i(idiv), .fbdiv_i(fbdiv),
    .odiv_i(odiv), .band_i(band), .above_thr_i(above), .busy_o(busy),
    .done_o(done), .result_o(result), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack)
  );

  assign bus_rdata = {30'b0, status};

  always @(posedge clk) cyc <= cyc + 1;

  // register slave: ack one cycle after request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && bus_ack) begin
        if (bus_we) begin
          wr_addr[wr_n % 64] <= bus_addr;
          wr_data[wr_n % 64] <= bus_wdata;
          wr_n <= wr_n + 1;
          if (bus_addr == A_CTRL) ctrl_cyc <= cyc;
        end else begin
          rd_n <= rd_n + 1;
          stat_cyc <= cyc;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_case(input bit ab, input logic [4:0] id, input logic [6:0] fb,
                          input logic [1:0] od, input logic [3:0] bd,
                          input logic [1:0] st, input logic [1:0] exp_res);
    int wb, rb, n, guard;
    logic [31:0] exp_w;
    exp_w = (32'(bd) << 20) | (32'(fb) << 9) | (32'(id) << 4) | (32'(od) << 2);
    wb = wr_n;
    rb = rd_n;
    status = st;
    @(negedge clk);
    req = 1'b1; above = ab; idiv = id; fbdiv = fb; odiv = od; band = bd;
    @(negedge clk);
    // R7: busy right after acceptance
    chk(busy === 1'b1, "R7 busy after accept", 32'(busy), 1);
    // R8: conflicting request while busy
    above = ~ab; idiv = ~id; fbdiv = ~fb; odiv = ~od; band = ~bd;
    @(negedge clk);
    req = 1'b0;
    guard = 0;
    while (done !== 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    // R6
    chk(done === 1'b1 && result === exp_res, "R6 result", 32'(result), 32'(exp_res));
    chk(busy === 1'b1, "R7 busy with done", 32'(busy), 1);
    @(negedge clk);
    // R7
    chk(done === 1'b0 && busy === 1'b0, "R7 done single cycle", {30'b0, done, busy}, 0);
    n = wr_n - wb;
    // R9
    chk(rd_n - rb == 1, "R9 one status read", 32'(rd_n - rb), 1);
    // R5
    chk(stat_cyc - ctrl_cyc >= LOCK, "R5 lock window", 32'(stat_cyc - ctrl_cyc), LOCK);
    if (ab) begin
      // R3
      chk(n == 2, "R3 write count", 32'(n), 2);
      chk(wr_addr[wb % 64] == A_CIF && wr_data[wb % 64] == 32'd1, "R3 divider raised first",
          wr_data[wb % 64], 1);
      // R2 R8
      chk(wr_addr[(wb + 1) % 64] == A_CTRL && wr_data[(wb + 1) % 64] == exp_w,
          "R2 R8 control word", wr_data[(wb + 1) % 64], exp_w);
    end else begin
      // R2 R8
      chk(wr_addr[wb % 64] == A_CTRL && wr_data[wb % 64] == exp_w, "R2 R8 control word",
          wr_data[wb % 64], exp_w);
      if (exp_res == 2'b00) begin
        // R4
        chk(n == 2, "R4 write count", 32'(n), 2);
        chk(wr_addr[(wb + 1) % 64] == A_CIF && wr_data[(wb + 1) % 64] == 32'd0,
            "R4 divider lowered after lock", wr_data[(wb + 1) % 64], 0);
      end else begin
        // R4
        chk(n == 1, "R4 no divider write on failure", 32'(n), 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0, "R1 reset state",
        {29'b0, busy, done, bus_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && bus_req === 1'b0, "R1 idle after reset", {30'b0, busy, bus_req}, 0);

    run_case(1'b1, 5'd1,  7'd35,  2'd0, 4'd0, 2'b01, 2'b00);
    run_case(1'b0, 5'd0,  7'd17,  2'd1, 4'd0, 2'b01, 2'b00);
    run_case(1'b0, 5'd1,  7'd47,  2'd3, 4'd5, 2'b00, 2'b01);
    run_case(1'b0, 5'd0,  7'd14,  2'd3, 4'd0, 2'b10, 2'b01);
    run_case(1'b1, 5'd1,  7'd44,  2'd0, 4'd2, 2'b11, 2'b10);
    run_case(1'b0, 5'd0,  7'd11,  2'd3, 4'd0, 2'b11, 2'b10);
    run_case(1'b1, 5'd31, 7'd127, 2'd3, 4'd15, 2'b00, 2'b01);
    run_case(1'b0, 5'd0,  7'd0,   2'd0, 4'd0, 2'b01, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule